// File: doc/BRIEF.md
# Single-Wire Control Bus Frame Transmitter

This block sends one frame of bytes on an open-drain, single-wire control bus of the kind used between consumer video equipment. The line idles high, and every node can only pull it low. All bit shapes are timed in microseconds, counted on a one-cycle enable (`tick_us`) derived from the system clock. A request carries a byte buffer, a byte count and a signal-free count. The block then waits until the line has been high long enough, sends a start bit, and sends each byte as ten bit slots: eight data bits, an end-of-message flag and an acknowledge slot.

Because the line is a wired-AND, the block reads it back at a fixed point inside the bits it sends as 1. During the first four header bits, a low reading means another initiator has won arbitration. In an acknowledge slot, the reading decides acknowledge or refusal, with the meaning reversed for broadcast frames. A line still held low after a 1-bit should have ended means another node is signalling an error. Every outcome is reported once, as a status code with a one-cycle `done` strobe. When arbitration is lost, a handoff pulse tells a receiver which header bit it must resume at.

Top module: `sbus_frame_tx`

## Requirements
- R1: The start bit pulls the line low for START_LOW_US ticks (default 3700) and lasts START_TOTAL_US ticks (default 4500) from its falling edge to the falling edge of the first data bit.
- R2: A data 0 is low for ZERO_LOW_US ticks (default 1500) and a data 1 is low for ONE_LOW_US ticks (default 600). Falling edges of consecutive data bits are BIT_TOTAL_US ticks apart (default 2400).
- R3: Byte k is taken from tx_msg[8k+7:8k] and sent as ten slots: bits 7 down to 0, then an end-of-message slot that is 1 only for byte tx_len-1, then an acknowledge slot that is always sent as 1.
- R4: The start bit begins only after the synchronized line has been high for more than tx_sft×BIT_TOTAL_US consecutive ticks. Any low on the line while waiting restarts that count, and the frame stays pending.
- R5: In header bits 0 to 3 sent as 1, the line is read SAMPLE_US ticks (default 850) after the falling edge. A low reading releases the line and ends the frame with status 3, with `rx_handoff` high in the same cycle as `done` and `handoff_bit` equal to the header bit index.
- R6: In each acknowledge slot, the line is read at SAMPLE_US. When tx_msg[3:0] is not 15, a low reading means acknowledged. When tx_msg[3:0] is 15 (broadcast), a high reading means acknowledged. A refusal ends the frame at CHECK_US ticks with status 2, and no further bits are sent.
- R7: In any bit sent as 1, a low line at CHECK_US ticks (default 1750) ends the frame with status 4. The line is released, and `busy` stays high until the line reads high again.
- R8: When the acknowledge slot of the last byte ends with an acknowledge, the frame ends with status 1 and the block returns to idle.
- R9: `done` is a one-cycle strobe. `status` changes only together with `done` and holds its value until the next `done`. The codes are 0 none, 1 success, 2 refused, 3 arbitration lost, 4 low-drive. After reset `status`, `done`, `busy` and `pull_low` are 0.
- R10: `tx_req` is ignored while `busy` is high, and also when tx_len is 0 or greater than MAX_BYTES. An ignored request produces no line activity and no `done`.
- R11: All timing advances only on cycles where `tick_us` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| bus_in | input | 1 | Sensed bus level (1 = high) |
| tx_req | input | 1 | Start-of-frame request |
| tx_msg | input | MAX_BYTES*8 | Frame bytes, byte k at bits 8k+7:8k |
| tx_len | input | $clog2(MAX_BYTES+1) | Number of bytes to send |
| tx_sft | input | SFT_W | Required free time in bit periods |
| pull_low | output | 1 | Enables the open-drain pull-down |
| busy | output | 1 | A frame is pending or in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| status | output | 3 | Outcome code of the last frame |
| rx_handoff | output | 1 | Arbitration lost; a receiver takes over |
| handoff_bit | output | 2 | Header bit index where arbitration was lost |

## Verification
On every cycle, the assertions check the shape of the reporting: a single-cycle `done` with a legal code, a status that does not change between strobes, a handoff only alongside an arbitration-lost outcome, a released line whenever the block is idle or has just seen a low-drive, and a cap on the length of any low pulse. Whether each bit has the right low time and spacing, the right data, end-of-message and acknowledge values, and whether each outcome arises from the right line reading, can be shown only by the bench. Its scenarios model other nodes acknowledging, refusing, overriding a header bit, holding the line in error and interrupting the free time, and it compares every pulse and outcome against a list worked out from the message.

// File: rtl/sbus_tx_pkg.sv
package sbus_tx_pkg;
   typedef enum logic [2:0] {
      TXS_NONE   = 3'd0,
      TXS_OK     = 3'd1,
      TXS_NACK   = 3'd2,
      TXS_ARB    = 3'd3,
      TXS_LOWDRV = 3'd4
   } txs_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WAIT,
      PH_START,
      PH_BIT,
      PH_DRAIN
   } phase_e;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic ff;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= 1'b1;
            else        ff <= d;
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d};
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sbus_free_timer.sv
module sbus_free_timer #(
   parameter int BIT_US = 2400,
   parameter int SFT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             line,
   input  logic [SFT_W-1:0] sft,
   output logic             free_ok
);
   localparam int LIMIT = BIT_US * ((1 << SFT_W) - 1) + 1;
   localparam int CNT_W = $clog2(LIMIT + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] thr;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                cnt <= '0;
      else if (!line)                            cnt <= '0;
      else if (tick && cnt < CNT_W'(LIMIT))      cnt <= cnt + 1'b1;

   assign thr     = CNT_W'(sft) * CNT_W'(BIT_US);
   assign free_ok = line && (cnt > thr);
endmodule

// File: rtl/sbus_bit_src.sv
module sbus_bit_src #(
   parameter int MAX_BYTES = 16,
   parameter int LEN_W     = $clog2(MAX_BYTES + 1),
   parameter int IDX_W     = $clog2(MAX_BYTES)
) (
   input  logic [MAX_BYTES*8-1:0] msg,
   input  logic [LEN_W-1:0]       len,
   input  logic [IDX_W-1:0]       byte_i,
   input  logic [3:0]             slot,
   output logic                   bit_val,
   output logic                   arb_win,
   output logic                   ack_slot,
   output logic                   last_byte,
   output logic                   bcast
);
   logic [7:0] byte_v;

   assign byte_v    = msg[{byte_i, 3'b000} +: 8];
   assign last_byte = (LEN_W'(byte_i) + 1'b1) == len;
   assign arb_win   = (byte_i == '0) && (slot < 4'd4);
   assign ack_slot  = (slot == 4'd9);
   assign bcast     = (msg[3:0] == 4'hF);

   always_comb begin
      if (slot < 4'd8)       bit_val = byte_v[3'd7 - slot[2:0]];
      else if (slot == 4'd8) bit_val = last_byte;
      else                   bit_val = 1'b1;
   end
endmodule

// File: rtl/sbus_frame_tx.sv
module sbus_frame_tx
   import sbus_tx_pkg::*;
#(
   parameter int MAX_BYTES      = 16,
   parameter int SFT_W          = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int START_LOW_US   = 3700,
   parameter int START_TOTAL_US = 4500,
   parameter int ZERO_LOW_US    = 1500,
   parameter int ONE_LOW_US     = 600,
   parameter int BIT_TOTAL_US   = 2400,
   parameter int SAMPLE_US      = 850,
   parameter int CHECK_US       = 1750
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_us,
   input  logic                          bus_in,
   input  logic                          tx_req,
   input  logic [MAX_BYTES*8-1:0]        tx_msg,
   input  logic [$clog2(MAX_BYTES+1)-1:0] tx_len,
   input  logic [SFT_W-1:0]              tx_sft,
   output logic                          pull_low,
   output logic                          busy,
   output logic                          done,
   output logic [2:0]                    status,
   output logic                          rx_handoff,
   output logic [1:0]                    handoff_bit
);
   localparam int LEN_W = $clog2(MAX_BYTES + 1);
   localparam int IDX_W = $clog2(MAX_BYTES);
   localparam int T_W   = $clog2(START_TOTAL_US);
   localparam logic [T_W-1:0] T_SLOW   = T_W'(START_LOW_US);
   localparam logic [T_W-1:0] T_SEND   = T_W'(START_TOTAL_US - 1);
   localparam logic [T_W-1:0] T_ZLOW   = T_W'(ZERO_LOW_US);
   localparam logic [T_W-1:0] T_OLOW   = T_W'(ONE_LOW_US);
   localparam logic [T_W-1:0] T_BEND   = T_W'(BIT_TOTAL_US - 1);
   localparam logic [T_W-1:0] T_SAMPLE = T_W'(SAMPLE_US);
   localparam logic [T_W-1:0] T_CHECK  = T_W'(CHECK_US);

   if (MAX_BYTES < 2) begin : g_bad_bytes
      $error("MAX_BYTES must be at least 2");
   end
   if (!(ONE_LOW_US < SAMPLE_US && SAMPLE_US < ZERO_LOW_US &&
         ZERO_LOW_US < CHECK_US && CHECK_US < BIT_TOTAL_US)) begin : g_bad_bit
      $error("bit timing must satisfy one_low < sample < zero_low < check < total");
   end
   if (!(START_LOW_US < START_TOTAL_US && BIT_TOTAL_US < START_TOTAL_US)) begin : g_bad_start
      $error("start bit timing inconsistent");
   end

   phase_e                 ph;
   logic [T_W-1:0]         t;
   logic [IDX_W-1:0]       byte_i;
   logic [3:0]             slot;
   logic [MAX_BYTES*8-1:0] msg_q;
   logic [LEN_W-1:0]       len_q;
   logic [SFT_W-1:0]       sft_q;
   logic                   nack_q;
   txs_e                   status_q;
   logic                   done_q, handoff_q;
   logic [1:0]             hbit_q;

   logic line, free_ok;
   logic bit_val, arb_win, ack_slot, last_byte, bcast;
   logic req_ok;

   sbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line));

   sbus_free_timer #(.BIT_US(BIT_TOTAL_US), .SFT_W(SFT_W)) u_free (
      .clk(clk), .rst_n(rst_n), .tick(tick_us), .line(line),
      .sft(sft_q), .free_ok(free_ok));

   sbus_bit_src #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_src (
      .msg(msg_q), .len(len_q), .byte_i(byte_i), .slot(slot),
      .bit_val(bit_val), .arb_win(arb_win), .ack_slot(ack_slot),
      .last_byte(last_byte), .bcast(bcast));

   assign req_ok = tx_req && (tx_len != '0) && (tx_len <= LEN_W'(MAX_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         t         <= '0;
         byte_i    <= '0;
         slot      <= '0;
         msg_q     <= '0;
         len_q     <= '0;
         sft_q     <= '0;
         nack_q    <= 1'b0;
         status_q  <= TXS_NONE;
         done_q    <= 1'b0;
         handoff_q <= 1'b0;
         hbit_q    <= '0;
      end else begin
         done_q    <= 1'b0;
         handoff_q <= 1'b0;
         case (ph)
            PH_IDLE: if (req_ok) begin
               msg_q  <= tx_msg;
               len_q  <= tx_len;
               sft_q  <= tx_sft;
               nack_q <= 1'b0;
               ph     <= PH_WAIT;
            end
            PH_WAIT: if (free_ok) begin
               t  <= '0;
               ph <= PH_START;
            end
            PH_START: if (tick_us) begin
               if (t == T_SEND) begin
                  t      <= '0;
                  byte_i <= '0;
                  slot   <= '0;
                  ph     <= PH_BIT;
               end else begin
                  t <= t + 1'b1;
               end
            end
            PH_BIT: if (tick_us) begin
               if (t == T_SAMPLE && bit_val && (arb_win || ack_slot)) begin
                  if (arb_win && !line) begin
                     status_q  <= TXS_ARB;
                     done_q    <= 1'b1;
                     handoff_q <= 1'b1;
                     hbit_q    <= slot[1:0];
                     ph        <= PH_IDLE;
                  end else begin
                     if (ack_slot) nack_q <= bcast ? !line : line;
                     t <= t + 1'b1;
                  end
               end else if (t == T_CHECK && bit_val) begin
                  if (!line) begin
                     status_q <= TXS_LOWDRV;
                     done_q   <= 1'b1;
                     ph       <= PH_DRAIN;
                  end else if (ack_slot && nack_q) begin
                     status_q <= TXS_NACK;
                     done_q   <= 1'b1;
                     ph       <= PH_IDLE;
                  end else begin
                     t <= t + 1'b1;
                  end
               end else if (t == T_BEND) begin
                  t <= '0;
                  if (ack_slot) begin
                     if (last_byte) begin
                        status_q <= TXS_OK;
                        done_q   <= 1'b1;
                        ph       <= PH_IDLE;
                     end else begin
                        byte_i <= byte_i + 1'b1;
                        slot   <= '0;
                     end
                  end else begin
                     slot <= slot + 1'b1;
                  end
               end else begin
                  t <= t + 1'b1;
               end
            end
            PH_DRAIN: if (line) ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      pull_low = 1'b0;
      if (ph == PH_START)    pull_low = (t < T_SLOW);
      else if (ph == PH_BIT) pull_low = (t < (bit_val ? T_OLOW : T_ZLOW));
   end

   assign busy        = (ph != PH_IDLE);
   assign done        = done_q;
   assign status      = status_q;
   assign rx_handoff  = handoff_q;
   assign handoff_bit = hbit_q;
endmodule

// File: rtl/sbus_frame_tx_chk.sv
module sbus_frame_tx_chk #(
   parameter int START_LOW_US = 3700
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_us,
   input logic       pull_low,
   input logic       busy,
   input logic       done,
   input logic [2:0] status,
   input logic       rx_handoff
);
   int unsigned lw_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  lw_cnt <= 0;
      else if (!pull_low)          lw_cnt <= 0;
      else if (tick_us)            lw_cnt <= lw_cnt + 1;

   p_low_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pull_low |-> lw_cnt < START_LOW_US);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status >= 3'd1 && status <= 3'd4));

   p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(status));

   p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_handoff |-> (done && status == 3'd3));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pull_low);

   p_finish_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 3'd4) |-> !busy);

   p_lowdrv_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 3'd4) |-> (busy && !pull_low));
endmodule

bind sbus_frame_tx sbus_frame_tx_chk #(.START_LOW_US(START_LOW_US)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .pull_low(pull_low),
   .busy(busy), .done(done), .status(status), .rx_handoff(rx_handoff));

// File: tb/sbus_frame_tx_tb.sv
module sbus_frame_tx_tb;
   localparam int MB = 4;
   localparam int SL = 74, STT = 90, ZL = 30, OL = 12, BT = 48, SP = 17, CK = 35;
   localparam int LW = $clog2(MB + 1);

   logic clk = 0, rst_n = 0, tick_us = 0;
   logic tx_req = 0;
   logic [MB*8-1:0] tx_msg = '0;
   logic [LW-1:0]   tx_len = '0;
   logic [3:0]      tx_sft = '0;
   logic pull_low, busy, done, rx_handoff;
   logic [2:0] status;
   logic [1:0] handoff_bit;
   logic resp_low = 0, force_low = 0;
   wire  bus_in = !(pull_low || resp_low || force_low);

   sbus_frame_tx #(.MAX_BYTES(MB), .SFT_W(4), .SYNC_STAGES(2),
      .START_LOW_US(SL), .START_TOTAL_US(STT), .ZERO_LOW_US(ZL), .ONE_LOW_US(OL),
      .BIT_TOTAL_US(BT), .SAMPLE_US(SP), .CHECK_US(CK)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_in(bus_in),
      .tx_req(tx_req), .tx_msg(tx_msg), .tx_len(tx_len), .tx_sft(tx_sft),
      .pull_low(pull_low), .busy(busy), .done(done), .status(status),
      .rx_handoff(rx_handoff), .handoff_bit(handoff_bit));

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int exp_low[$], exp_gap[$], exp_st[$], exp_hb[$];
   int hold_tab[0:63];
   int pulse_n = -1, resp_cnt = 0;
   int tick_total = 0, rise_tick = 0, low_cnt = 0, gap_meas = 0;
   bit have_rise = 0, prev_pl = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial forever begin
      @(negedge clk);
      tick_us = ~tick_us;
   end

   // monitor, scoreboard and modelled remote nodes
   initial forever begin
      @(posedge clk); #1;
      if (rst_n) begin
         if (tick_us) begin
            tick_total++;
            if (prev_pl) low_cnt++;
            if (resp_low) begin
               resp_cnt--;
               if (resp_cnt <= 0) resp_low = 0;
            end
         end
         if (!prev_pl && pull_low) begin
            gap_meas  = have_rise ? tick_total - rise_tick : 0;
            rise_tick = tick_total;
            have_rise = 1;
            low_cnt   = 0;
            pulse_n++;
            if (pulse_n < 64 && hold_tab[pulse_n] > 0) begin
               resp_low = 1;
               resp_cnt = hold_tab[pulse_n];
            end
         end
         if (prev_pl && !pull_low) begin
            if (exp_low.size() == 0) chk(0, "R3 unexpected pulse", pulse_n, -1);
            else begin
               int el, eg;
               el = exp_low.pop_front();
               eg = exp_gap.pop_front();
               chk(low_cnt == el, "R1/R2 low ticks", low_cnt, el);
               chk(gap_meas == eg, "R1/R2 bit spacing", gap_meas, eg);
            end
         end
         if (done) begin
            if (exp_st.size() == 0) chk(0, "R9 unexpected done", status, 0);
            else begin
               int es, eh;
               es = exp_st.pop_front();
               eh = exp_hb.pop_front();
               chk(status == 3'(es), "R9 status code", status, es);
               if (es == 3) begin
                  chk(rx_handoff == 1'b1, "R5 handoff pulse", rx_handoff, 1);
                  chk(handoff_bit == 2'(eh), "R5 handoff bit", handoff_bit, eh);
               end else begin
                  chk(rx_handoff == 1'b0, "R5 no handoff", rx_handoff, 0);
               end
            end
         end
         prev_pl = pull_low;
      end
   end

   // driver: compute the expected pulses and outcome, then issue the request
   task automatic send(input logic [MB*8-1:0] m, input int len, input int sft,
                       input int npulse, input int est, input int ehb);
      for (int k = 0; k < npulse; k++) begin
         if (k == 0) begin
            exp_low.push_back(SL);
            exp_gap.push_back(0);
         end else begin
            int b, s;
            bit v;
            b = (k - 1) / 10;
            s = (k - 1) % 10;
            if (s < 8)       v = m[b*8 + 7 - s];
            else if (s == 8) v = (b == len - 1);
            else             v = 1'b1;
            exp_low.push_back(v ? OL : ZL);
            exp_gap.push_back(k == 1 ? STT : BT);
         end
      end
      exp_st.push_back(est);
      exp_hb.push_back(ehb);
      pulse_n   = -1;
      have_rise = 0;
      @(negedge clk);
      tx_msg = m; tx_len = LW'(len); tx_sft = 4'(sft); tx_req = 1;
      @(negedge clk);
      tx_req = 0;
   endtask

   task automatic clear_resp();
      for (int i = 0; i < 64; i++) hold_tab[i] = 0;
   endtask

   task automatic wait_idle(input string tag);
      int n;
      n = 0;
      while (busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
      chk(exp_low.size() == 0 && exp_st.size() == 0, tag, exp_low.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      clear_resp();
      repeat (5) @(negedge clk);
      // R9: reset values
      chk(status == 3'd0 && !done && !busy && !pull_low, "R9 reset state",
          {status, done, busy, pull_low}, 0);
      rst_n = 1;
      repeat (400) @(negedge clk);

      // R6/R8/R3: directed two-byte frame acknowledged by a receiver
      clear_resp();
      hold_tab[10] = ZL;
      hold_tab[20] = ZL;
      send(32'h0000_A540, 2, 3, 21, 1, 0);
      repeat (600) @(negedge clk);
      // R10: a request while busy is ignored
      @(negedge clk); tx_msg = 32'hFFFF_FFFF; tx_len = 1; tx_req = 1;
      @(negedge clk); tx_req = 0;
      wait_idle("R8 directed frame complete");
      repeat (300) @(negedge clk);
      chk(!busy && !pull_low, "R10 busy request not queued", busy, 0);

      // R6/R8: broadcast frame, nobody objects
      clear_resp();
      send(32'h0000_004F, 1, 1, 11, 1, 0);
      wait_idle("R8 broadcast acknowledged");

      // R6: directed frame without any receiver is refused at first ack slot
      clear_resp();
      send(32'h0000_A540, 2, 1, 11, 2, 0);
      wait_idle("R6 directed refusal");

      // R6: broadcast frame refused by a node pulling the ack slot low
      clear_resp();
      hold_tab[10] = ZL;
      send(32'h0000_004F, 1, 1, 11, 2, 0);
      wait_idle("R6 broadcast refusal");

      // R5: another initiator overrides header bit 1
      clear_resp();
      hold_tab[2] = ZL;
      send(32'h0000_004F, 1, 1, 3, 3, 1);
      wait_idle("R5 arbitration lost");

      // R7: error low-drive during data bit 4 (a 1)
      clear_resp();
      hold_tab[5] = 72;
      send(32'h0000_004F, 1, 1, 6, 4, 0);
      while (!done) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(busy && !pull_low, "R7 drain holds busy, line released", {busy, pull_low}, 2);
      wait_idle("R7 low-drive handled");

      // R4/R11: free-time wait, restarted by a glitch
      clear_resp();
      repeat (200) @(negedge clk);
      force_low = 1;
      send(32'h0000_004F, 1, 2, 11, 1, 0);
      repeat (100) @(negedge clk);
      chk(!pull_low, "R4 no start while bus low", pull_low, 0);
      force_low = 0;
      repeat (120) @(negedge clk);
      chk(!pull_low && busy, "R4 still waiting before free time", pull_low, 0);
      force_low = 1;
      repeat (4) @(negedge clk);
      force_low = 0;
      begin
         int t0, dt, n;
         t0 = tick_total;
         n = 0;
         while (!pull_low && n < 2000) begin
            @(negedge clk);
            n++;
         end
         dt = tick_total - t0;
         chk(dt >= 2*BT + 1 && dt <= 2*BT + 3, "R4 start after free time", dt, 2*BT + 1);
      end
      wait_idle("R4 frame after glitch");

      // R10: invalid lengths are ignored
      @(negedge clk); tx_len = 0; tx_req = 1;
      @(negedge clk); tx_req = 0;
      repeat (300) @(negedge clk);
      chk(!busy && !pull_low, "R10 zero length ignored", busy, 0);
      @(negedge clk); tx_len = LW'(MB + 1); tx_req = 1;
      @(negedge clk); tx_req = 0;
      repeat (300) @(negedge clk);
      chk(!busy && !pull_low, "R10 oversize length ignored", busy, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule